// File: doc/BRIEF.md
# Vector-by-Tile Multiply-Accumulate Core

This core takes one request per cycle naming an activation vector, a weight tile and an accumulator entry. It fetches the vector and the tile from two read-only buffers that sit outside the core. It multiplies the vector by the transposed tile to produce one 32-bit sum per output lane. It then adds those sums into the named entry of an internal accumulator memory, or writes them into it unchanged when the request carries the clear flag. A reduction over K input tiles is done by issuing K requests to the same entry: the first one with clear set, the rest without it.

Work flows through four registered steps: accept and buffer fetch, multiply, lane summation together with the accumulator read, and write-back. When two requests to the same entry are accepted on consecutive cycles, the second one takes its old value from the write-back step rather than from the memory, so no sum is lost and the core never stalls. Results leave the core only through a store-read port, which returns each lane narrowed to 8 bits.

The request side follows valid/ready rules. `req_ready` is low while reset is asserted. It rises at the first clock edge after reset is released and then stays high. A request is taken on every rising edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable until that edge. The core never applies back-pressure after reset, so a requester that holds `req_valid` high issues one operation per cycle.

Top module: `vmm_core`

## Requirements
- R1: Output lane j of an operation equals the sum over i of act[i]*wgt[j][i]. Operands are signed 8-bit values and the arithmetic is 32-bit. Activation lane i sits at `inp_rd_data[8i+7:8i]`. Weight row j, column i sits at `wgt_rd_data` bits starting at 8*(16j+i).
- R2: A request with `req_clear` low adds its lane results to the current contents of entry `req_acc_idx` and writes the sum back. K such requests after one clearing request leave the full K-tile dot product in the entry.
- R3: A request with `req_clear` high writes its lane results alone into the entry and discards the earlier contents.
- R4: When `st_rd_en` is sampled high, `st_rd_valid` and `st_rd_data` are updated at the following edge and `st_rd_valid` is high for exactly that cycle. Lane j of `st_rd_data` (bits 8j+7:8j) holds the low 8 bits of the entry's 32-bit lane j, wrapping with no saturation.
- R5: An operation accepted at edge E changes its entry at edge E+3. A store read sampled at E+1 or E+2 returns the earlier contents. A store read sampled at E+3 already returns the new contents.
- R6: Requests accepted on consecutive cycles are all applied, including when they target the same entry back to back. The result equals issuing the same requests with idle gaps between them.
- R7: `req_ready` is low during reset and rises at the first edge after reset release. In the cycle a request is offered while ready, `buf_rd_en` is high and `inp_rd_addr` and `wgt_rd_addr` equal the request's indices. The buffers return their data one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Core accepts a request this cycle |
| req_inp_idx | input | INP_LOG | Activation buffer entry |
| req_wgt_idx | input | WGT_LOG | Weight buffer entry |
| req_acc_idx | input | ACC_LOG | Accumulator entry to update |
| req_clear | input | 1 | Overwrite the entry instead of adding to it |
| buf_rd_en | output | 1 | Read strobe for both operand buffers |
| inp_rd_addr | output | INP_LOG | Activation buffer address |
| inp_rd_data | input | 8*LANES_IN | Activation vector, one cycle after the strobe |
| wgt_rd_addr | output | WGT_LOG | Weight buffer address |
| wgt_rd_data | input | 8*LANES_IN*LANES_OUT | Transposed weight tile, one cycle after the strobe |
| st_rd_en | input | 1 | Store-read request |
| st_rd_idx | input | ACC_LOG | Accumulator entry to read out |
| st_rd_valid | output | 1 | Store-read data valid |
| st_rd_data | output | 8*LANES_OUT | Narrowed lanes of the read entry |

## Verification
Two functions of this core can hit the same accumulator entry at the same edge: a store read, and the write-back of an accumulation into that entry. The bench provokes this by issuing a clearing request to an entry that already holds a known value, then store-reading that entry on the three edges that follow acceptance. The first two readouts must return the old value and the third must return the new one. A second collision is checked inside the core: the write-back of one request and the accumulator read of the next request to the same entry, when the two are accepted on consecutive cycles. The bench judges it by back-to-back and interleaved request runs, whose final contents must match a reference model of the dot products.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
  // Fixed number formats of the datapath
  localparam int ELEM_W = 8;
  localparam int PROD_W = 2 * ELEM_W;
  localparam int ACC_W  = 32;

  typedef logic signed [ELEM_W-1:0] elem_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // Readout narrowing: keep the low bits, wrap on overflow
  function automatic elem_t narrow(acc_t v);
    return v[ELEM_W-1:0];
  endfunction
endpackage

// File: rtl/vmm_mul_stage.sv
module vmm_mul_stage
  import vmm_pkg::*;
#(
  parameter int LANES_IN  = 16,
  parameter int LANES_OUT = 16,
  localparam int ACT_BITS  = LANES_IN * ELEM_W,
  localparam int TILE_BITS = LANES_OUT * LANES_IN * ELEM_W
) (
  input  logic                                  clk,
  input  logic [ACT_BITS-1:0]                   act_flat,
  input  logic [TILE_BITS-1:0]                  wgt_flat,
  output prod_t [LANES_OUT-1:0][LANES_IN-1:0]   prod_q
);
  // One registered signed product per (output lane, input lane) pair
  for (genvar j = 0; j < LANES_OUT; j++) begin : g_row
    for (genvar i = 0; i < LANES_IN; i++) begin : g_col
      elem_t a_e, w_e;
      assign a_e = act_flat[i*ELEM_W +: ELEM_W];
      assign w_e = wgt_flat[(j*LANES_IN+i)*ELEM_W +: ELEM_W];
      always_ff @(posedge clk) begin
        prod_q[j][i] <= prod_t'(a_e) * prod_t'(w_e);
      end
    end
  end
endmodule

// File: rtl/vmm_lane_sum.sv
module vmm_lane_sum
  import vmm_pkg::*;
#(
  parameter int LANES_IN  = 16,
  parameter int LANES_OUT = 16
) (
  input  logic                                  clk,
  input  prod_t [LANES_OUT-1:0][LANES_IN-1:0]   prod,
  output acc_t  [LANES_OUT-1:0]                 sum_q
);
  // Per output lane: reduce all products at accumulator width, then register
  for (genvar j = 0; j < LANES_OUT; j++) begin : g_lane
    acc_t s;
    always_comb begin
      s = '0;
      for (int k = 0; k < LANES_IN; k++) begin
        s = s + acc_t'(prod[j][k]);
      end
    end
    always_ff @(posedge clk) begin
      sum_q[j] <= s;
    end
  end
endmodule

// File: rtl/vmm_acc_mem.sv
module vmm_acc_mem
  import vmm_pkg::*;
#(
  parameter int LANES_OUT = 16,
  parameter int ACC_LOG   = 4,
  localparam int DEPTH    = 1 << ACC_LOG,
  localparam int RES_BITS = LANES_OUT * ELEM_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ACC_LOG-1:0]          rd_idx,
  output acc_t [LANES_OUT-1:0]        old_q,
  input  logic                        wr_en,
  input  logic [ACC_LOG-1:0]          wr_idx,
  input  acc_t [LANES_OUT-1:0]        wr_data,
  input  logic                        st_en,
  input  logic [ACC_LOG-1:0]          st_idx,
  output logic                        st_valid_q,
  output logic [RES_BITS-1:0]         st_data_q
);
  acc_t [LANES_OUT-1:0] mem [DEPTH];

  // A read at the same edge as a write to the same entry takes the new value
  logic hit_rd, hit_st;
  acc_t [LANES_OUT-1:0] rd_src, st_src;
  assign hit_rd = wr_en && (wr_idx == rd_idx);
  assign hit_st = wr_en && (wr_idx == st_idx);
  assign rd_src = hit_rd ? wr_data : mem[rd_idx];
  assign st_src = hit_st ? wr_data : mem[st_idx];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    old_q <= rd_src;
    if (st_en) begin
      for (int j = 0; j < LANES_OUT; j++) begin
        st_data_q[j*ELEM_W +: ELEM_W] <= narrow(st_src[j]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_valid_q <= 1'b0;
    else        st_valid_q <= st_en;
  end

  assert_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_idx) |=> old_q == $past(wr_data));

  assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data));

  assert_st_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |=> st_valid_q);

  assert_st_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !st_en |=> !st_valid_q);
endmodule

// File: rtl/vmm_core.sv
module vmm_core
  import vmm_pkg::*;
#(
  parameter int LANES_IN  = 16,
  parameter int LANES_OUT = 16,
  parameter int INP_LOG   = 6,
  parameter int WGT_LOG   = 4,
  parameter int ACC_LOG   = 4,
  localparam int ACT_BITS  = LANES_IN * ELEM_W,
  localparam int TILE_BITS = LANES_OUT * LANES_IN * ELEM_W,
  localparam int RES_BITS  = LANES_OUT * ELEM_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [INP_LOG-1:0]   req_inp_idx,
  input  logic [WGT_LOG-1:0]   req_wgt_idx,
  input  logic [ACC_LOG-1:0]   req_acc_idx,
  input  logic                 req_clear,
  output logic                 buf_rd_en,
  output logic [INP_LOG-1:0]   inp_rd_addr,
  input  logic [ACT_BITS-1:0]  inp_rd_data,
  output logic [WGT_LOG-1:0]   wgt_rd_addr,
  input  logic [TILE_BITS-1:0] wgt_rd_data,
  input  logic                 st_rd_en,
  input  logic [ACC_LOG-1:0]   st_rd_idx,
  output logic                 st_rd_valid,
  output logic [RES_BITS-1:0]  st_rd_data
);
  // Handshake: ready once out of reset, never back-pressures afterwards
  logic ready_q, fire;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign req_ready   = ready_q;
  assign fire        = req_valid && ready_q;
  assign buf_rd_en   = fire;
  assign inp_rd_addr = req_inp_idx;
  assign wgt_rd_addr = req_wgt_idx;

  // Control tags travelling alongside the datapath
  logic               p1_v, p2_v, p3_v;
  logic [ACC_LOG-1:0] p1_a, p2_a, p3_a;
  logic               p1_c, p2_c, p3_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v <= 1'b0;
      p2_v <= 1'b0;
      p3_v <= 1'b0;
    end else begin
      p1_v <= fire;
      p2_v <= p1_v;
      p3_v <= p2_v;
    end
  end

  always_ff @(posedge clk) begin
    p1_a <= req_acc_idx;
    p1_c <= req_clear;
    p2_a <= p1_a;
    p2_c <= p1_c;
    p3_a <= p2_a;
    p3_c <= p2_c;
  end

  prod_t [LANES_OUT-1:0][LANES_IN-1:0] prod;
  acc_t  [LANES_OUT-1:0]               lane_sum, old_val, wr_val;

  vmm_mul_stage #(.LANES_IN(LANES_IN), .LANES_OUT(LANES_OUT)) u_mul (
    .clk      (clk),
    .act_flat (inp_rd_data),
    .wgt_flat (wgt_rd_data),
    .prod_q   (prod)
  );

  vmm_lane_sum #(.LANES_IN(LANES_IN), .LANES_OUT(LANES_OUT)) u_sum (
    .clk   (clk),
    .prod  (prod),
    .sum_q (lane_sum)
  );

  // Write-back value: overwrite on clear, otherwise accumulate
  for (genvar j = 0; j < LANES_OUT; j++) begin : g_wb
    assign wr_val[j] = p3_c ? lane_sum[j] : old_val[j] + lane_sum[j];
  end

  vmm_acc_mem #(.LANES_OUT(LANES_OUT), .ACC_LOG(ACC_LOG)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (p2_a),
    .old_q      (old_val),
    .wr_en      (p3_v),
    .wr_idx     (p3_a),
    .wr_data    (wr_val),
    .st_en      (st_rd_en),
    .st_idx     (st_rd_idx),
    .st_valid_q (st_rd_valid),
    .st_data_q  (st_rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_ready_reset_R7: assert (!req_ready);
    end
  end

  assert_issue_reaches_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ##2 (p3_v && p3_a == $past(req_acc_idx, 3) && p3_c == $past(req_clear, 3)));
endmodule

// File: tb/vmm_core_test.sv
module vmm_core_test;
  localparam int LI = 16;
  localparam int LO = 16;
  localparam int IL = 6;
  localparam int WL = 4;
  localparam int AL = 4;
  localparam int ACTB = LI * 8;
  localparam int TILB = LO * LI * 8;
  localparam int RESB = LO * 8;
  localparam int NACT = 1 << IL;
  localparam int NWGT = 1 << WL;
  localparam int NACC = 1 << AL;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_clear;
  logic [IL-1:0] req_inp_idx;
  logic [WL-1:0] req_wgt_idx;
  logic [AL-1:0] req_acc_idx;
  logic buf_rd_en;
  logic [IL-1:0] inp_rd_addr;
  logic [WL-1:0] wgt_rd_addr;
  logic [ACTB-1:0] inp_rd_data;
  logic [TILB-1:0] wgt_rd_data;
  logic st_rd_en, st_rd_valid;
  logic [AL-1:0] st_rd_idx;
  logic [RESB-1:0] st_rd_data;

  always #5 clk = ~clk;

  vmm_core #(.LANES_IN(LI), .LANES_OUT(LO), .INP_LOG(IL), .WGT_LOG(WL), .ACC_LOG(AL)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_inp_idx(req_inp_idx), .req_wgt_idx(req_wgt_idx), .req_acc_idx(req_acc_idx),
    .req_clear(req_clear), .buf_rd_en(buf_rd_en), .inp_rd_addr(inp_rd_addr),
    .inp_rd_data(inp_rd_data), .wgt_rd_addr(wgt_rd_addr), .wgt_rd_data(wgt_rd_data),
    .st_rd_en(st_rd_en), .st_rd_idx(st_rd_idx), .st_rd_valid(st_rd_valid),
    .st_rd_data(st_rd_data)
  );

  // Operand buffer models with one-cycle read latency
  logic [ACTB-1:0] inp_mem [NACT];
  logic [TILB-1:0] wgt_mem [NWGT];
  always @(posedge clk) begin
    if (buf_rd_en) begin
      inp_rd_data <= inp_mem[inp_rd_addr];
      wgt_rd_data <= wgt_mem[wgt_rd_addr];
    end
  end

  int ref_acc [NACC][LO];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check_bit(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic check_vec(string req, logic [RESB-1:0] got, logic [RESB-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic int dot(int a, int w, int j);
    int s = 0;
    for (int i = 0; i < LI; i++) begin
      byte x, y;
      x = inp_mem[a][i*8 +: 8];
      y = wgt_mem[w][(j*LI+i)*8 +: 8];
      s = s + int'(x) * int'(y);
    end
    return s;
  endfunction

  function automatic logic [RESB-1:0] exp_vec(int e);
    logic [RESB-1:0] v;
    for (int j = 0; j < LO; j++) v[j*8 +: 8] = ref_acc[e][j][7:0];
    return v;
  endfunction

  task automatic model_apply(int a, int w, int e, bit clr);
    for (int j = 0; j < LO; j++)
      ref_acc[e][j] = (clr ? 0 : ref_acc[e][j]) + dot(a, w, j);
  endtask

  // Called at a negative edge; returns at the negative edge after acceptance
  task automatic issue(int a, int w, int e, bit clr);
    req_valid = 1'b1;
    req_inp_idx = IL'(a);
    req_wgt_idx = WL'(w);
    req_acc_idx = AL'(e);
    req_clear = clr;
    model_apply(a, w, e, clr);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  task automatic readout(int e, output logic [RESB-1:0] got);
    st_rd_en = 1'b1;
    st_rd_idx = AL'(e);
    @(posedge clk);
    @(negedge clk);
    st_rd_en = 1'b0;
    got = st_rd_data;
  endtask

  task automatic check_entry(string req, int e);
    logic [RESB-1:0] got;
    readout(e, got);
    check_vec(req, got, exp_vec(e));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_clear = 1'b0;
    req_inp_idx = '0; req_wgt_idx = '0; req_acc_idx = '0;
    st_rd_en = 1'b0; st_rd_idx = '0;
    repeat (3) @(negedge clk);
    check_bit("R7 ready low in reset", req_ready, 1'b0);
    check_bit("R4 no store valid in reset", st_rd_valid, 1'b0);
    rst_n = 1'b1;
    #1;
    check_bit("R7 ready low before first edge", req_ready, 1'b0);
    @(negedge clk);
    check_bit("R7 ready high after first edge", req_ready, 1'b1);
  endtask

  task automatic t_handshake();
    check_bit("R7 no fetch when idle", buf_rd_en, 1'b0);
    req_valid = 1'b1; req_inp_idx = IL'(37); req_wgt_idx = WL'(9);
    req_acc_idx = AL'(3); req_clear = 1'b1;
    model_apply(37, 9, 3, 1'b1);
    #1;
    check_bit("R7 fetch strobe", buf_rd_en, 1'b1);
    check_bit("R7 act address", inp_rd_addr == IL'(37), 1'b1);
    check_bit("R7 weight address", wgt_rd_addr == WL'(9), 1'b1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    check_entry("R1 handshake result", 3);
  endtask

  task automatic t_wrap();
    // act 60: lane0=100, others 0; weight 15: row j col0 = j+1 -> lane j = 100*(j+1)
    inp_mem[60] = '0;
    inp_mem[60][7:0] = 8'd100;
    wgt_mem[15] = '0;
    for (int j = 0; j < LO; j++) wgt_mem[15][(j*LI)*8 +: 8] = 8'(j + 1);
    issue(60, 15, 1, 1'b1);
    drain();
    st_rd_en = 1'b1; st_rd_idx = AL'(1);
    @(posedge clk);
    @(negedge clk);
    st_rd_en = 1'b0;
    check_bit("R4 store valid pulse", st_rd_valid, 1'b1);
    check_vec("R4 wrap narrowing", st_rd_data, exp_vec(1));
    @(negedge clk);
    check_bit("R4 store valid single cycle", st_rd_valid, 1'b0);
  endtask

  task automatic t_ktile();
    issue(4, 2, 2, 1'b1);
    for (int k = 0; k < 3; k++) begin
      repeat (3) @(negedge clk);
      issue(5 + k, 3 + k, 2, 1'b0);
    end
    drain();
    check_entry("R2 K-tile reduction", 2);
  endtask

  task automatic t_clear();
    issue(11, 7, 2, 1'b1);
    drain();
    check_entry("R3 clear discards old", 2);
  endtask

  task automatic t_b2b();
    issue(12, 1, 9, 1'b1);
    issue(13, 4, 9, 1'b0);
    issue(14, 5, 9, 1'b0);
    issue(15, 6, 9, 1'b0);
    drain();
    check_entry("R6 back-to-back same entry", 9);
    issue(16, 0, 10, 1'b1);
    issue(17, 8, 11, 1'b1);
    issue(18, 9, 10, 1'b0);
    issue(19, 10, 11, 1'b0);
    issue(20, 11, 10, 1'b0);
    drain();
    check_entry("R6 interleaved entry A", 10);
    check_entry("R6 interleaved entry B", 11);
  endtask

  task automatic t_collision();
    logic [RESB-1:0] old_v, got;
    issue(21, 12, 7, 1'b1);
    drain();
    old_v = exp_vec(7);
    issue(22, 13, 7, 1'b1);
    readout(7, got);
    check_vec("R5 read at E+1 old", got, old_v);
    readout(7, got);
    check_vec("R5 read at E+2 old", got, old_v);
    readout(7, got);
    check_vec("R5 read at E+3 new", got, exp_vec(7));
  endtask

  task automatic t_random();
    for (int e = 0; e < NACC; e++) issue(e, e % 14, e, 1'b1);
    for (int n = 0; n < 40; n++) begin
      int gap;
      gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      issue($urandom_range(0, 59), $urandom_range(0, 13), $urandom_range(0, NACC - 1),
            ($urandom_range(0, 7) == 0));
    end
    drain();
    for (int e = 0; e < NACC; e++) check_entry("R1 R2 random reference", e);
  endtask

  initial begin
    for (int a = 0; a < NACT; a++)
      for (int i = 0; i < LI; i++) inp_mem[a][i*8 +: 8] = 8'($urandom_range(0, 255));
    for (int w = 0; w < NWGT; w++)
      for (int k = 0; k < LI * LO; k++) wgt_mem[w][k*8 +: 8] = 8'($urandom_range(0, 255));
    for (int e = 0; e < NACC; e++)
      for (int j = 0; j < LO; j++) ref_acc[e][j] = 0;
    @(negedge clk);
    t_reset();
    t_handshake();
    t_wrap();
    t_ktile();
    t_clear();
    t_b2b();
    t_collision();
    t_random();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule